// File: doc/BRIEF.md
# Challenge-Response Authentication Sequencer

This block runs one authentication session against a remote token that holds a shared secret and a hash engine. A trigger input starts the session. The block then drives a bit-level single-wire bus master through a request/acknowledge handshake. In each attempt it resets the bus and writes the stored challenge. It resets the bus again, waits a short settle delay, and then holds a strong pullup while the token computes. After a third reset it reads back the token's message authentication code. Each incoming bit is compared with the stored expected response as it arrives, so the full code is never buffered.

A failed attempt is retried, up to a configured number of attempts. This hides contact bounce and line noise. The session ends with a pass strobe as soon as one attempt matches. It ends with a fail strobe only when every allowed attempt has mismatched. If any bus reset gets no presence answer, the session ends at once with a token-absent strobe instead. The physical bus timing, the hash engine and the storage of the challenge/response pair sit outside this block. The delay and pullup durations are counted in system clocks, so a simulation can use short values.

Top module: `auth_seq`

## Requirements
- R1: After reset, `bus_req`, `spu_en`, `done`, `pass`, `fail` and `absent` are all low, and they stay low until a trigger arrives.
- R2: `cfg_trig_pol` selects the active level of `trig_in` (1 = high). With `cfg_trig_edge`=1, a session starts only on the transition into the active level, so holding the active level does not start a second session. With `cfg_trig_edge`=0, a session starts whenever the input is at its active level while the block is idle. An inactive input never starts a session.
- R3: Trigger activity while a session is running is ignored. Each session produces exactly one `done` pulse.
- R4: Each attempt issues bus operations in this fixed order: reset, then CH_BITS writes of `challenge` with bit 0 first, then reset, reset, then RS_BITS reads. The `bus_op` codes are 0 = reset/presence, 1 = write bit, 2 = read bit.
- R5: After the second reset of an attempt is acknowledged, `spu_en` stays low for DLY_CYC cycles. It then stays high for exactly SPU_CYC cycles, and no bus request is outstanding while it is high.
- R6: The read bit i (bit 0 first) is compared with `response[i]`. Any single differing bit fails the attempt. All RS_BITS reads are still issued after a mismatch.
- R7: A session makes at most `cfg_retries`+1 attempts. A further attempt starts only after the previous one mismatched.
- R8: The first matching attempt ends the session with `pass` and `done` high together for one cycle.
- R9: If every allowed attempt mismatches, the session ends with `fail` and `done` high together for one cycle.
- R10: If a reset is acknowledged with `bus_rbit`=0 (no presence), the session ends with `absent` and `done` high for one cycle, never `fail`, and no further bus operation is issued.
- R11: Once `bus_req` rises, it stays high with `bus_op` and `bus_wbit` unchanged until the cycle in which `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Session trigger |
| cfg_trig_edge | input | 1 | 1 = edge start, 0 = level start |
| cfg_trig_pol | input | 1 | 1 = trigger active high |
| cfg_retries | input | $clog2(MAX_ATTEMPTS) | Attempts allowed minus one |
| challenge | input | CH_BITS | Stored challenge |
| response | input | RS_BITS | Stored expected response |
| bus_req | output | 1 | Bus operation request |
| bus_op | output | 2 | Operation code: 0 reset, 1 write, 2 read |
| bus_wbit | output | 1 | Bit to write |
| bus_ack | input | 1 | Operation complete (one cycle) |
| bus_rbit | input | 1 | Presence (reset) or read data, valid with ack |
| spu_en | output | 1 | Strong pullup enable |
| done | output | 1 | Session end strobe |
| pass | output | 1 | Authentication passed strobe |
| fail | output | 1 | Authentication failed strobe |
| absent | output | 1 | Token-absent strobe |

## Verification
A bad bit index or a skipped state changes the order or count of bus operations, or the challenge bits seen on `bus_wbit`, within the attempt where it happens. A miscounting delay counter shows up as a wrong `spu_en` delay or width in the first attempt. A mismatch flag that is lost or set falsely is seen only at the end of the attempt. It appears as a wrong result strobe, or as a wrong number of attempts measured in reset and read counts. Presence handling errors show up as `fail` in place of `absent`, or as bus operations issued after `done`.

// File: rtl/auth_pkg.sv
package auth_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RST1, S_WR, S_RST2, S_DLY, S_SPU, S_RST3, S_RD, S_EVAL
  } seq_state_e;
endpackage

// File: rtl/auth_trig.sv
module auth_trig (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  input  logic cfg_edge,
  input  logic cfg_pol,
  output logic start
);
  logic act, act_r, act_q;

  assign act = cfg_pol ? trig_in : ~trig_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_r <= 1'b0;
      act_q <= 1'b0;
    end else begin
      act_r <= act;
      act_q <= act_r;
    end
  end

  assign start = cfg_edge ? (act_r & ~act_q) : act_r;
endmodule

// File: rtl/auth_timer.sv
module auth_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/auth_cmp.sv
module auth_cmp (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic exp_bit,
  output logic mismatch
);
  always_ff @(posedge clk) begin
    if (rst || clr)                         mismatch <= 1'b0;
    else if (bit_valid && bit_in != exp_bit) mismatch <= 1'b1;
  end

  // R6: once a difference is seen it stays until the next attempt clears it
  p_sticky_mismatch_r6: assert property (@(posedge clk) disable iff (rst)
    mismatch && !clr |=> mismatch);
endmodule

// File: rtl/auth_seq.sv
module auth_seq
  import auth_pkg::*;
#(
  parameter int CH_BITS      = 64,
  parameter int RS_BITS      = 160,
  parameter int MAX_ATTEMPTS = 8,
  parameter int DLY_CYC      = 100000,
  parameter int SPU_CYC      = 1700000,
  localparam int RW   = $clog2(MAX_ATTEMPTS),
  localparam int CIW  = $clog2(CH_BITS),
  localparam int IDXW = $clog2(RS_BITS),
  localparam int TW   = $clog2((DLY_CYC > SPU_CYC ? DLY_CYC : SPU_CYC) + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_in,
  input  logic               cfg_trig_edge,
  input  logic               cfg_trig_pol,
  input  logic [RW-1:0]      cfg_retries,
  input  logic [CH_BITS-1:0] challenge,
  input  logic [RS_BITS-1:0] response,
  output logic               bus_req,
  output logic [1:0]         bus_op,
  output logic               bus_wbit,
  input  logic               bus_ack,
  input  logic               bus_rbit,
  output logic               spu_en,
  output logic               done,
  output logic               pass,
  output logic               fail,
  output logic               absent
);
  seq_state_e    state;
  logic [IDXW-1:0] bit_idx;
  logic [RW-1:0] attempt, retries_q;
  logic          start, tmr_load, tmr_zero, mismatch, acked;
  logic [TW-1:0] tmr_val;
  bus_op_e       op_now;
  logic [CIW-1:0] ch_idx;

  assign ch_idx = bit_idx[CIW-1:0];
  assign acked  = bus_req && bus_ack;

  auth_trig u_trig (
    .clk(clk), .rst(rst), .trig_in(trig_in),
    .cfg_edge(cfg_trig_edge), .cfg_pol(cfg_trig_pol), .start(start)
  );

  assign tmr_load = (state == S_RST2 && acked && bus_rbit) ||
                    (state == S_DLY && tmr_zero);
  assign tmr_val  = (state == S_DLY) ? TW'(SPU_CYC - 1) : TW'(DLY_CYC - 1);

  auth_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  auth_cmp u_cmp (
    .clk(clk), .rst(rst), .clr(state == S_RST1),
    .bit_valid(state == S_RD && acked), .bit_in(bus_rbit),
    .exp_bit(response[bit_idx]), .mismatch(mismatch)
  );

  always_comb begin
    case (state)
      S_RST1, S_RST2, S_RST3: op_now = OP_RESET;
      S_WR:                   op_now = OP_WRITE;
      default:                op_now = OP_READ;
    endcase
  end

  assign spu_en = (state == S_SPU);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      bit_idx   <= '0;
      attempt   <= '0;
      retries_q <= '0;
      bus_req   <= 1'b0;
      bus_op    <= OP_RESET;
      bus_wbit  <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      absent    <= 1'b0;
    end else begin
      done   <= 1'b0;
      pass   <= 1'b0;
      fail   <= 1'b0;
      absent <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state     <= S_RST1;
          attempt   <= '0;
          retries_q <= cfg_retries;
        end
        S_DLY: if (tmr_zero) state <= S_SPU;
        S_SPU: if (tmr_zero) state <= S_RST3;
        S_EVAL: begin
          if (!mismatch) begin
            pass  <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (attempt == retries_q) begin
            fail  <= 1'b1;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            attempt <= attempt + 1'b1;
            state   <= S_RST1;
          end
        end
        default: begin
          if (!bus_req) begin
            bus_req  <= 1'b1;
            bus_op   <= op_now;
            bus_wbit <= (state == S_WR) ? challenge[ch_idx] : 1'b0;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            if (op_now == OP_RESET && !bus_rbit) begin
              absent <= 1'b1;
              done   <= 1'b1;
              state  <= S_IDLE;
            end else begin
              case (state)
                S_RST1: begin state <= S_WR; bit_idx <= '0; end
                S_RST2: state <= S_DLY;
                S_RST3: begin state <= S_RD; bit_idx <= '0; end
                S_WR: begin
                  if (bit_idx == IDXW'(CH_BITS - 1)) state <= S_RST2;
                  else bit_idx <= bit_idx + 1'b1;
                end
                default: begin
                  if (bit_idx == IDXW'(RS_BITS - 1)) state <= S_EVAL;
                  else bit_idx <= bit_idx + 1'b1;
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  // R11: request and its payload hold until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_op) && $stable(bus_wbit));

  // R5: no bus traffic while the strong pullup is on
  p_spu_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    spu_en |-> !bus_req);

  // R8: exactly one result accompanies done
  p_one_result_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $countones({pass, fail, absent}) == 1);

  // R9: no result strobe without done
  p_result_done_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pass, fail, absent}) && ((pass || fail || absent) -> done));
endmodule

// File: tb/tb_auth_seq.sv
module tb_auth_seq;
  localparam int CHB = 64, RSB = 160, DLY = 5, SPU = 12, SEQN = CHB + RSB + 3;
  localparam logic [CHB-1:0] CHAL = 64'hA5C3_0F1E_9B77_2D48;
  localparam logic [RSB-1:0] RESP = 160'h3C9E_07A1_55D2_F00D_8B41_6E2C_91F7_0A3B_D4E8_1265;

  logic clk = 0, rst = 1, trig = 0, cfg_e = 1, cfg_p = 1;
  logic [2:0] cfg_r = 0;
  logic bus_req, bus_wbit, bus_ack, bus_rbit, spu_en, done, pass, fail, absent;
  logic [1:0] bus_op;

  int checks = 0, errors = 0, cyc = 0;
  int rst_cnt, wr_cnt, rd_cnt, seq, order_err, chal_err, dly_err, spu_tot, done_cnt = 0;
  int fail_n = 0, err_pos = 0, absent_idx = 0, dcnt = 0;
  bit after_r2 = 0, pend = 0;
  logic [2:0] res;

  always #2.5 clk = ~clk;

  auth_seq #(.CH_BITS(CHB), .RS_BITS(RSB), .MAX_ATTEMPTS(8), .DLY_CYC(DLY), .SPU_CYC(SPU)) dut (
    .clk(clk), .rst(rst), .trig_in(trig), .cfg_trig_edge(cfg_e), .cfg_trig_pol(cfg_p),
    .cfg_retries(cfg_r), .challenge(CHAL), .response(RESP), .bus_req(bus_req),
    .bus_op(bus_op), .bus_wbit(bus_wbit), .bus_ack(bus_ack), .bus_rbit(bus_rbit),
    .spu_en(spu_en), .done(done), .pass(pass), .fail(fail), .absent(absent));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_op(input int s);
    if (s == 0 || s == CHB + 1 || s == CHB + 2) return 0;
    if (s <= CHB) return 1;
    return 2;
  endfunction

  task automatic clear_counts();
    rst_cnt = 0; wr_cnt = 0; rd_cnt = 0; seq = 0; order_err = 0;
    chal_err = 0; dly_err = 0; spu_tot = 0; after_r2 = 0; dcnt = 0;
  endtask

  // token/bus model and monitor
  initial begin
    bus_ack = 0; bus_rbit = 0; clear_counts();
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (spu_en) spu_tot++;
        if (after_r2) begin
          if (!spu_en) dcnt++;
          else begin
            if (dcnt != DLY) dly_err++;
            after_r2 = 0; dcnt = 0;
          end
        end
        if (done) begin done_cnt++; res = {pass, fail, absent}; end
      end
      bus_ack = 0;
      if (bus_req && !rst) begin
        if (!pend) pend = 1;
        else begin
          pend = 0; bus_ack = 1;
          if (int'(bus_op) != exp_op(seq % SEQN)) order_err++;
          case (bus_op)
            2'd0: begin
              rst_cnt++;
              bus_rbit = (rst_cnt != absent_idx);
              if (seq % SEQN == CHB + 1 && bus_rbit) after_r2 = 1;
            end
            2'd1: begin
              if (bus_wbit != CHAL[wr_cnt % CHB]) chal_err++;
              wr_cnt++;
            end
            default: begin
              bus_rbit = RESP[rd_cnt % RSB] ^ ((rd_cnt / RSB) < fail_n && (rd_cnt % RSB) == err_pos);
              rd_cnt++;
            end
          endcase
          seq++;
        end
      end
    end
  end

  initial begin
    while (cyc < 180000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic wait_done(input int d0);
    int t = 0;
    while (done_cnt == d0 && t < 30000) begin @(negedge clk); t++; end
    repeat (10) @(negedge clk);
  endtask

  task automatic session(input bit e, input bit p, input int r, input int fn, input int ep, input int ab);
    int d0, att, exp_res;
    @(negedge clk);
    cfg_e = e; cfg_p = p; trig = ~p; cfg_r = 3'(r);
    fail_n = fn; err_pos = ep; absent_idx = ab; clear_counts();
    repeat (3) @(negedge clk);
    d0 = done_cnt;
    trig = p;
    repeat (2) @(negedge clk);
    trig = ~p;
    wait_done(d0);
    chk(done_cnt - d0 == 1, "R3 one done per session", done_cnt - d0, 1);
    chk(order_err == 0, "R4 op order", order_err, 0);
    chk(chal_err == 0, "R4 challenge bits", chal_err, 0);
    chk(dly_err == 0, "R5 pullup delay", dly_err, 0);
    if (ab != 0) begin
      chk(res == 3'b001, "R10 absent result", res, 1);
      chk(rst_cnt == ab, "R10 no ops after absent", rst_cnt, ab);
      chk(wr_cnt == CHB * ((ab + 1) / 3), "R10 writes", wr_cnt, CHB * ((ab + 1) / 3));
      chk(rd_cnt == RSB * ((ab - 1) / 3), "R10 reads", rd_cnt, RSB * ((ab - 1) / 3));
      chk(spu_tot == SPU * (ab / 3), "R5 pullup width", spu_tot, SPU * (ab / 3));
    end else begin
      att = (fn <= r) ? fn + 1 : r + 1;
      exp_res = (fn <= r) ? 4 : 2;
      chk(res == 3'(exp_res), (fn <= r) ? "R8 pass result" : "R9 fail result", res, exp_res);
      chk(rst_cnt == 3 * att, "R7 attempt count", rst_cnt, 3 * att);
      chk(wr_cnt == CHB * att, "R4 write count", wr_cnt, CHB * att);
      chk(rd_cnt == RSB * att, "R6 full read after mismatch", rd_cnt, RSB * att);
      chk(spu_tot == SPU * att, "R5 pullup width", spu_tot, SPU * att);
    end
  endtask

  initial begin
    int rl[4] = '{0, 1, 3, 7};
    int k = 0, d0;
    repeat (4) @(negedge clk);
    chk(!bus_req && !spu_en && !done && !pass && !fail && !absent, "R1 reset outputs",
        {bus_req, spu_en, done, pass, fail, absent}, 0);
    rst = 0;
    repeat (20) @(negedge clk);
    chk(!bus_req && !done && !spu_en, "R1 idle without trigger", {bus_req, done, spu_en}, 0);

    // R2: inactive level in level mode, each polarity
    for (int p = 0; p < 2; p++) begin
      cfg_e = 0; cfg_p = p[0]; trig = ~p[0];
      repeat (30) @(negedge clk);
      chk(rst_cnt == 0 && done_cnt == 0, "R2 inactive level no start", rst_cnt, 0);
    end

    // main sweep over retries, failing-attempt counts and trigger modes
    foreach (rl[i]) begin
      for (int fn = 0; fn <= rl[i] + 1; fn++) begin
        session(k[0], k[1], rl[i], fn, (fn == 1) ? 159 : (fn * 37) % RSB, 0);
        k++;
      end
    end
    session(1, 1, 2, 1, 0, 0);

    // R10: token removal at different resets
    session(1, 1, 7, 8, 0, 1);
    session(0, 0, 7, 8, 0, 2);
    session(1, 0, 7, 8, 0, 3);
    session(0, 1, 7, 8, 0, 5);

    // R2: edge mode with the trigger held active -> single session
    @(negedge clk);
    cfg_e = 1; cfg_p = 1; trig = 0; cfg_r = 0; fail_n = 0; absent_idx = 0; clear_counts();
    repeat (3) @(negedge clk);
    d0 = done_cnt; trig = 1;
    wait_done(d0);
    repeat (20) @(negedge clk);
    chk(done_cnt - d0 == 1 && rst_cnt == 3, "R2 edge mode held level", rst_cnt, 3);
    trig = 0;
    repeat (5) @(negedge clk);

    // R3: trigger noise during a session is ignored
    clear_counts(); cfg_r = 1; fail_n = 1; err_pos = 40;
    repeat (3) @(negedge clk);
    d0 = done_cnt; trig = 1;
    repeat (2) @(negedge clk);
    trig = 0;
    for (int t = 0; t < 8; t++) begin
      repeat (40) @(negedge clk);
      trig = ~trig;
    end
    trig = 0;
    wait_done(d0);
    chk(done_cnt - d0 == 1, "R3 noise single done", done_cnt - d0, 1);
    chk(rst_cnt == 6, "R3 noise no restart", rst_cnt, 6);
    chk(res == 3'b100, "R3 noise result pass", res, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule